// File: doc/BRIEF.md
# Quadrature Decoder with Selectable Resolution

This block turns the two phase-shifted square waves of one incremental encoder axis into counting events. Channels A and B are a quarter cycle apart. Each channel passes through a synchronizer. A resolution code then selects which transitions qualify: every edge of both channels, both edges of A only, or the rising edge of A only. Each qualifying transition updates a wrapping up/down position counter and produces a one-clock count pulse. A direction flag accompanies the pulse.

The direction flag is registered one clock before the count pulse. An external counter that latches direction on the pulse's rising edge therefore always sees a settled level. Code 00 is an illegal resolution and turns counting off. A sample in which both channels change at once is treated as a glitch and is discarded.

Top module: `qdec_axis`

## Requirements
- R1: While rst_ni is low and on the first clock after its release, pos_o is 0, cnt_pulse_o is 0 and up_o is 1. Channel levels present at reset release (including A=1, B=1) produce no count.
- R2: With mode_i = 2'b10, every transition of one channel produces one count, giving four counts per encoder cycle.
- R3: With mode_i = 2'b01, only transitions of A count, giving two per cycle. Transitions of B alone leave pos_o unchanged and emit no pulse.
- R4: With mode_i = 2'b11, only a rising edge of A counts, giving one per cycle. The direction is up when B is low at that edge and down when B is high.
- R5: When A leads B the count goes up and up_o is 1. When B leads A the count goes down and up_o is 0.
- R6: With mode_i = 2'b00, no input activity changes pos_o or raises cnt_pulse_o.
- R7: If both channels change in the same synchronized sample, pos_o is unchanged and no pulse is emitted.
- R8: up_o changes only on the clock edge just before a pulse. It already shows the new direction in the cycle before cnt_pulse_o rises, and each qualifying transition produces a pulse exactly one clock long.
- R9: pos_o changes only together with cnt_pulse_o, by +1 when the direction is up and -1 when it is down. It wraps modulo 2^CNT_W, so a down count from 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_a_i | input | 1 | Encoder channel A, asynchronous |
| ch_b_i | input | 1 | Encoder channel B, asynchronous |
| mode_i | input | 2 | Resolution: 10 = 4x, 01 = 2x, 11 = 1x, 00 = off (illegal) |
| cnt_pulse_o | output | 1 | One-clock pulse per qualifying transition |
| up_o | output | 1 | Direction: 1 up, 0 down |
| pos_o | output | CNT_W | Position counter |

## Verification
Four properties are checked on every cycle. The counter moves only with a pulse, and then by one in the direction that up_o showed beforehand. A direction change is always followed by a pulse. An off code two cycles earlier forbids a pulse. The mode-specific choice of which edges qualify, the A-leads-B direction rule, glitch rejection, wrap-around and start-up with high channel levels are shown only by the bench scenarios. Those scenarios compare pos_o, the pulse count and the direction level against a reference model after each input change.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    RES_OFF = 2'b00,
    RES_X2  = 2'b01,
    RES_X4  = 2'b10,
    RES_X1  = 2'b11
  } res_mode_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic a_o,
  output logic b_o,
  output logic valid_o
);
  localparam int WW = $clog2(STAGES + 1);

  logic [STAGES-1:0] a_ff, b_ff;
  logic [WW-1:0]     warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_ff[0] <= 1'b0;
      b_ff[0] <= 1'b0;
    end else begin
      a_ff[0] <= a_i;
      b_ff[0] <= b_i;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_ff[i] <= 1'b0;
        b_ff[i] <= 1'b0;
      end else begin
        a_ff[i] <= a_ff[i-1];
        b_ff[i] <= b_ff[i-1];
      end
    end
  end

  // output is a real sample once the chain has filled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     warm_q <= '0;
    else if (warm_q != WW'(STAGES)) warm_q <= warm_q + 1'b1;
  end

  assign a_o     = a_ff[STAGES-1];
  assign b_o     = b_ff[STAGES-1];
  assign valid_o = (warm_q == WW'(STAGES));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       valid_i,
  input  logic [1:0] mode_i,
  output logic       ev_o,
  output logic       up_o
);
  res_mode_e mode;
  logic a_q, b_q, primed_q;
  logic a_chg, b_chg, qual, dir;

  assign mode  = res_mode_e'(mode_i);
  assign a_chg = a_i ^ a_q;
  assign b_chg = b_i ^ b_q;

  always_comb begin
    qual = 1'b0;
    dir  = 1'b1;
    if (primed_q && (a_chg ^ b_chg)) begin
      unique case (mode)
        RES_X4: begin
          qual = 1'b1;
          dir  = a_chg ? (a_i ^ b_i) : ~(a_i ^ b_i);
        end
        RES_X2: begin
          qual = a_chg;
          dir  = a_i ^ b_i;
        end
        RES_X1: begin
          qual = a_chg & a_i;
          dir  = ~b_i;
        end
        default: qual = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= 1'b0;
      b_q      <= 1'b0;
      primed_q <= 1'b0;
      ev_o     <= 1'b0;
      up_o     <= 1'b1;
    end else begin
      a_q      <= a_i;
      b_q      <= b_i;
      primed_q <= valid_i;
      ev_o     <= qual;
      if (qual) up_o <= dir;
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic             up_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= ev_i;
      if (ev_i) pos_o <= up_i ? pos_o + ONE : pos_o - ONE;
    end
  end
endmodule

// File: rtl/qdec_axis.sv
module qdec_axis #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_a_i,
  input  logic             ch_b_i,
  input  logic [1:0]       mode_i,
  output logic             cnt_pulse_o,
  output logic             up_o,
  output logic [CNT_W-1:0] pos_o
);
  logic a_s, b_s, s_valid, ev;

  qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .a_i(ch_a_i), .b_i(ch_b_i),
    .a_o(a_s), .b_o(b_s), .valid_o(s_valid)
  );

  qdec_decode u_dec (
    .clk_i, .rst_ni, .a_i(a_s), .b_i(b_s), .valid_i(s_valid),
    .mode_i, .ev_o(ev), .up_o
  );

  qdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .ev_i(ev), .up_i(up_o),
    .pulse_o(cnt_pulse_o), .pos_o
  );
endmodule

// File: rtl/qdec_axis_chk.sv
module qdec_axis_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             cnt_pulse_o,
  input logic             up_o,
  input logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_pulse_o |-> pos_o == ($past(up_o) ? $past(pos_o) + ONE : $past(pos_o) - ONE));

  // R9
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_pulse_o |-> $stable(pos_o));

  // R8
  dir_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(up_o) |-> ##1 cnt_pulse_o);

  // R6
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i, 2) == 2'b00) |-> !cnt_pulse_o);
endmodule

bind qdec_axis qdec_axis_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .cnt_pulse_o(cnt_pulse_o), .up_o(up_o), .pos_o(pos_o)
);

// File: tb/qdec_axis_tb.sv
module qdec_axis_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_a = 1'b0, ch_b = 1'b0;
  logic [1:0] mode = 2'b10;
  logic cnt_pulse, up;
  logic [CW-1:0] pos;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  int pulses = 0;
  logic last_up = 1'b1, up_before = 1'b1, prev_up = 1'b1;
  logic [CW-1:0] exp_pos = '0;
  logic exp_up = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdec_axis #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_a_i(ch_a), .ch_b_i(ch_b),
    .mode_i(mode), .cnt_pulse_o(cnt_pulse), .up_o(up), .pos_o(pos)
  );

  always @(negedge clk) begin
    if (rst_n && cnt_pulse) begin
      pulses++;
      last_up   = up;
      up_before = prev_up;
    end
    prev_up = up;
  end

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_delta(logic [1:0] m, logic a0, logic b0, logic a1, logic b1);
    logic ca, cb;
    ca = a0 ^ a1;
    cb = b0 ^ b1;
    if (m == 2'b00 || (ca == cb)) return 0;
    case (m)
      2'b10: if (ca) return (a1 ^ b1) ? 1 : -1;
             else    return (a1 == b1) ? 1 : -1;
      2'b01: if (ca) return (a1 ^ b1) ? 1 : -1;
      2'b11: if (ca && a1) return b1 ? -1 : 1;
      default: return 0;
    endcase
    return 0;
  endfunction

  function automatic string tag(logic [1:0] m, logic a0, logic b0, logic a1, logic b1);
    if ((a0 ^ a1) && (b0 ^ b1)) return "R7";
    case (m)
      2'b10: return "R2";
      2'b01: return "R3";
      2'b11: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic a1, input logic b1);
    int d;
    string t;
    d = exp_delta(mode, ch_a, ch_b, a1, b1);
    t = tag(mode, ch_a, ch_b, a1, b1);
    @(negedge clk);
    pulses = 0;
    ch_a = a1;
    ch_b = b1;
    repeat (6) @(negedge clk);
    exp_pos = exp_pos + CW'(d);
    chk({t, " pos"}, pos, exp_pos);
    chk({t, " pulses"}, CW'(pulses), CW'(d != 0));
    if (d != 0) begin
      exp_up = (d > 0);
      chk("R5 dir at pulse", CW'(last_up), CW'(exp_up));
      chk("R8 dir before pulse", CW'(up_before), CW'(exp_up));
    end
    chk("R8 dir held", CW'(up), CW'(exp_up));
  endtask

  task automatic fwd_cycle();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
  endtask

  task automatic rev_cycle();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog all R actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] p0;
    void'($urandom(32'h5eed_1234));
    // R1: reset with both channels high
    ch_a = 1; ch_b = 1;
    repeat (3) @(negedge clk);
    chk("R1 pos in reset", pos, '0);
    chk("R1 pulse in reset", CW'(cnt_pulse), '0);
    chk("R1 dir in reset", CW'(up), CW'(1));
    rst_n = 1'b1;
    pulses = 0;
    repeat (8) @(negedge clk);
    chk("R1 no start count", pos, '0);
    chk("R1 no start pulse", CW'(pulses), '0);
    step(0, 1);
    exp_pos = pos;

    // return to 00 with one legal step at a time
    step(0, 0);
    // R9 wrap: force known zero by reset
    @(negedge clk); rst_n = 1'b0; ch_a = 0; ch_b = 0;
    @(negedge clk); rst_n = 1'b1;
    exp_pos = '0; exp_up = 1'b1;
    repeat (6) @(negedge clk);
    mode = 2'b10;
    step(0, 1);
    chk("R9 wrap down", pos, {CW{1'b1}});
    step(0, 0);
    chk("R9 wrap back", pos, '0);

    // directed cycles in each mode
    mode = 2'b10; p0 = pos; fwd_cycle(); chk("R2 four up", pos - p0, CW'(4));
    p0 = pos; rev_cycle(); chk("R2 four down", p0 - pos, CW'(4));
    mode = 2'b01; p0 = pos; fwd_cycle(); chk("R3 two up", pos - p0, CW'(2));
    p0 = pos; rev_cycle(); chk("R3 two down", p0 - pos, CW'(2));
    mode = 2'b11; p0 = pos; fwd_cycle(); chk("R4 one up", pos - p0, CW'(1));
    p0 = pos; rev_cycle(); chk("R4 one down", p0 - pos, CW'(1));
    mode = 2'b00; p0 = pos; fwd_cycle(); rev_cycle(); chk("R6 off", pos, p0);
    mode = 2'b10; p0 = pos;
    step(1, 1); step(0, 0); chk("R7 double change", pos, p0);

    // random walk
    for (int i = 0; i < 400; i++) begin
      int r;
      if ($urandom_range(0, 15) == 0) mode = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 9);
      if (r < 5)      step(~ch_a, ch_b);
      else if (r < 9) step(ch_a, ~ch_b);
      else            step(~ch_a, ~ch_b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule